// File: doc/BRIEF.md
# Receiver Mute and Wakeup Controller

This block sits next to a UART receiver and decides whether each received character is reported to software. The receiver hands it a word (data bits plus a mark bit in the top position) with a one-cycle valid strobe, and an idle-line strobe. While the block is in mute mode, characters are swallowed: the receive-ready flag stays low and the data register keeps its value. Software may request mute on or off, and hardware leaves mute on its own when the selected wakeup condition is seen.

Two wakeup methods are available. With the idle-line method, an idle-line strobe ends mute. With the address-mark method, a word whose top bit is 1 is an address mark. A mark whose low four bits equal the node address ends mute and is itself delivered. A mark that names another node puts an active receiver back into mute. Software writes to the mute state are limited. In address-mark mode they are ignored while a delivered character is still unread. In idle-line mode, a request to enter mute is ignored until at least one character has been delivered since reset.

Top module: `rx_mute_ctrl`

## Requirements
- R1: After reset, `mute`, `rxne`, `wake_pulse` and `rx_data` are all 0.
- R2: When `rx_valid` is high and the word is accepted, `rxne` is 1 and `rx_data` holds the word from the next cycle. `rd_ack` clears `rxne` one cycle later. If a word is accepted in the same cycle as `rd_ack`, `rxne` stays 1.
- R3: While muted, a character that does not wake the block leaves `rxne` and `rx_data` unchanged.
- R4: With `wake_sel`=0 and the block muted, `idle_det` clears `mute` in the next cycle, and `wake_pulse` is high for exactly that one cycle. With `wake_sel`=1, `idle_det` has no effect.
- R5: With `wake_sel`=1 and the block muted, a word with bit DATA_W-1 = 1 and bits [3:0] equal to `node_addr` clears `mute`, raises `wake_pulse` for one cycle and is delivered as in R2.
- R6: With `wake_sel`=1 and the block active, a word with bit DATA_W-1 = 1 and bits [3:0] not equal to `node_addr` sets `mute` in the next cycle and is not delivered. A matching mark received while active is delivered normally.
- R7: When no rule blocks it, `mute_set` sets `mute` and `mute_clr` clears it in the next cycle. If both are high in the same cycle, set wins.
- R8: With `wake_sel`=1, `mute_set` and `mute_clr` have no effect while `rxne` is 1.
- R9: With `wake_sel`=0, `mute_set` has no effect until a character has been delivered since reset.
- R10: When a hardware wake or re-mute happens in the same cycle as a software request, the hardware outcome decides `mute`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_sel | input | 1 | Wakeup method: 0 = idle line, 1 = address mark |
| node_addr | input | ADDR_W | Address of this node |
| rx_word | input | DATA_W | Received word; top bit is the mark bit |
| rx_valid | input | 1 | One-cycle strobe: `rx_word` is a new character |
| idle_det | input | 1 | One-cycle strobe: an idle line was detected |
| mute_set | input | 1 | Software request to enter mute |
| mute_clr | input | 1 | Software request to leave mute |
| rd_ack | input | 1 | Software read of the data register; clears `rxne` |
| mute | output | 1 | Current mute state |
| rxne | output | 1 | Received data ready (gated by mute) |
| rx_data | output | DATA_W | Last delivered word |
| wake_pulse | output | 1 | One-cycle pulse when hardware ends mute |

## Verification
A hardware wakeup and a software write to the mute state can fall in the same cycle. Examples are a matching address mark arriving with `mute_set` high, or `idle_det` arriving with `mute_set` high. A second collision is a word being accepted in the same cycle as `rd_ack`. Directed steps drive these collisions on purpose, and a random phase drives them by chance. A behavioural model in the bench predicts the mute state, the ready flag, the data and the pulse on every clock. It expects the hardware outcome to win the mute state, and it expects a new word to win the ready flag.

// File: rtl/rx_mute_ctrl.sv
module rx_mute_ctrl #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_sel,
  input  logic [ADDR_W-1:0] node_addr,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic              idle_det,
  input  logic              mute_set,
  input  logic              mute_clr,
  input  logic              rd_ack,
  output logic              mute,
  output logic              rxne,
  output logic [DATA_W-1:0] rx_data,
  output logic              wake_pulse
);

  localparam int MARK_BIT = DATA_W - 1;

  logic seen_byte;
  logic is_mark, addr_hit;
  logic wake_idle, wake_addr, hw_wake, hw_remute;
  logic sw_open, sw_set_ok, deliver;
  logic mute_nx;

  assign is_mark   = rx_valid & rx_word[MARK_BIT];
  assign addr_hit  = rx_word[ADDR_W-1:0] == node_addr;

  assign wake_idle = mute & ~wake_sel & idle_det;
  assign wake_addr = mute & wake_sel & is_mark & addr_hit;
  assign hw_wake   = wake_idle | wake_addr;
  assign hw_remute = ~mute & wake_sel & is_mark & ~addr_hit;

  assign sw_open   = ~(wake_sel & rxne);
  assign sw_set_ok = sw_open & mute_set & (wake_sel | seen_byte);

  assign deliver   = rx_valid & ((~mute & ~hw_remute) | wake_addr);

  always_comb begin
    mute_nx = mute;
    if (hw_wake)                    mute_nx = 1'b0;
    else if (hw_remute)             mute_nx = 1'b1;
    else if (sw_set_ok)             mute_nx = 1'b1;
    else if (sw_open && mute_clr)   mute_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mute       <= 1'b0;
      rxne       <= 1'b0;
      rx_data    <= '0;
      wake_pulse <= 1'b0;
      seen_byte  <= 1'b0;
    end else begin
      mute       <= mute_nx;
      wake_pulse <= hw_wake;
      if (deliver) begin
        rxne      <= 1'b1;
        rx_data   <= rx_word;
        seen_byte <= 1'b1;
      end else if (rd_ack) begin
        rxne <= 1'b0;
      end
    end
  end

  assert_rxne_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne) |-> $past(rx_valid));

  assert_idle_mute_holds_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute && !wake_sel) |=> $stable(rx_data));

  assert_wake_leaves_mute_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!mute && $past(mute)));

  assert_mismatch_remutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute && wake_sel && rx_valid && rx_word[MARK_BIT] && rx_word[ADDR_W-1:0] != node_addr)
      |=> (mute && !$rose(rxne)));

  assert_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sel && rxne && !rx_valid) |=> $stable(mute));

  assert_no_early_idle_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_sel && !seen_byte && !mute) |=> !mute);

endmodule

// File: tb/test_rx_mute_ctrl.sv
module test_rx_mute_ctrl;
  localparam int DW = 9;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_sel = 1'b0;
  logic [AW-1:0] node_addr = 4'h5;
  logic [DW-1:0] rx_word = '0;
  logic rx_valid = 1'b0, idle_det = 1'b0, mute_set = 1'b0, mute_clr = 1'b0, rd_ack = 1'b0;
  logic mute, rxne, wake_pulse;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  bit m_mute, m_rxne, m_wake, m_seen;
  bit [DW-1:0] m_data;

  always #10 clk = ~clk;

  rx_mute_ctrl #(.DATA_W(DW), .ADDR_W(AW)) i_rx_mute_ctrl (
    .clk, .rst_n, .wake_sel, .node_addr, .rx_word, .rx_valid, .idle_det,
    .mute_set, .mute_clr, .rd_ack, .mute, .rxne, .rx_data, .wake_pulse);

  always @(posedge clk) begin
    bit mark, hit, woke, remute, take, allow;
    if (!rst_n) begin
      m_mute = 0; m_rxne = 0; m_wake = 0; m_seen = 0; m_data = '0;
    end else begin
      mark = rx_valid && rx_word[DW-1];
      hit = (rx_word[3:0] == node_addr);
      woke = 0; remute = 0; take = 0;
      if (m_mute) begin
        if (wake_sel == 0 && idle_det) woke = 1;
        if (wake_sel == 1 && mark && hit) begin woke = 1; take = 1; end
      end else if (rx_valid) begin
        if (wake_sel && mark && !hit) remute = 1;
        else take = 1;
      end
      allow = !(wake_sel && m_rxne);
      m_wake = woke;
      if (woke) m_mute = 0;
      else if (remute) m_mute = 1;
      else if (allow && mute_set && (wake_sel || m_seen)) m_mute = 1;
      else if (allow && mute_clr) m_mute = 0;
      if (take) begin m_rxne = 1; m_data = rx_word; m_seen = 1; end
      else if (rd_ack) m_rxne = 0;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (mute !== m_mute || rxne !== m_rxne || rx_data !== m_data || wake_pulse !== m_wake) begin
      errors++;
      $display("FAIL %s model: got mute=%b rxne=%b data=%h wake=%b expected mute=%b rxne=%b data=%h wake=%b",
               cur_req, mute, rxne, rx_data, wake_pulse, m_mute, m_rxne, m_data, m_wake);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    rx_valid = 0; idle_det = 0; mute_set = 0; mute_clr = 0; rd_ack = 0;
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s directed: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(logic [DW-1:0] w);
    rx_word = w; rx_valid = 1; tick();
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cur_req = "R1";
    chk("R1", {mute, rxne, wake_pulse}, 0); chk("R1", rx_data, 0);

    cur_req = "R9";
    mute_set = 1; tick(); chk("R9", mute, 0);

    cur_req = "R2";
    send(9'h0A3); chk("R2", rxne, 1); chk("R2", rx_data, 9'h0A3);
    rd_ack = 1; tick(); chk("R2", rxne, 0);
    rd_ack = 1; send(9'h03C); chk("R2", rxne, 1); chk("R2", rx_data, 9'h03C);
    rd_ack = 1; tick();

    cur_req = "R7";
    mute_set = 1; tick(); chk("R7", mute, 1);
    cur_req = "R3";
    send(9'h055); chk("R3", rxne, 0); chk("R3", rx_data, 9'h03C);

    cur_req = "R4";
    idle_det = 1; tick(); chk("R4", mute, 0); chk("R4", wake_pulse, 1);
    tick(); chk("R4", wake_pulse, 0);

    cur_req = "R7";
    mute_set = 1; mute_clr = 1; tick(); chk("R7", mute, 1);
    mute_clr = 1; tick(); chk("R7", mute, 0);

    cur_req = "R6";
    wake_sel = 1;
    send(9'h107); chk("R6", mute, 1); chk("R6", rxne, 0);
    cur_req = "R4";
    idle_det = 1; tick(); chk("R4", mute, 1); chk("R4", wake_pulse, 0);
    cur_req = "R3";
    send(9'h015); chk("R3", rxne, 0); chk("R3", rx_data, 9'h03C);

    cur_req = "R5";
    send(9'h115); chk("R5", mute, 0); chk("R5", wake_pulse, 1);
    chk("R5", rxne, 1); chk("R5", rx_data, 9'h115);

    cur_req = "R8";
    mute_set = 1; tick(); chk("R8", mute, 0);
    send(9'h1F2); chk("R6", mute, 1);
    mute_clr = 1; tick(); chk("R8", mute, 1);
    rd_ack = 1; tick(); chk("R2", rxne, 0);
    mute_clr = 1; tick(); chk("R7", mute, 0);
    send(9'h125); chk("R6", rxne, 1); chk("R6", mute, 0);
    rd_ack = 1; tick();

    cur_req = "R10";
    mute_set = 1; tick(); chk("R7", mute, 1);
    rx_word = 9'h1A5; rx_valid = 1; mute_set = 1; tick();
    chk("R10", mute, 0); chk("R10", rxne, 1);
    rd_ack = 1; tick();
    rx_word = 9'h1A9; rx_valid = 1; mute_clr = 1; tick(); chk("R10", mute, 1);
    wake_sel = 0;
    idle_det = 1; mute_set = 1; tick(); chk("R10", mute, 0);

    cur_req = "R10 random";
    for (int i = 0; i < 2000; i++) begin
      if (($urandom % 64) == 0) wake_sel = ~wake_sel;
      rx_word = DW'($urandom);
      if (($urandom % 3) == 0) rx_word[3:0] = node_addr;
      rx_valid = ($urandom % 3) == 0;
      idle_det = ($urandom % 8) == 0;
      mute_set = ($urandom % 6) == 0;
      mute_clr = ($urandom % 6) == 0;
      rd_ack = ($urandom % 4) == 0;
      tick();
    end

    tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule